// File: doc/BRIEF.md
# FFT Twiddle Angle Sequencer

This block sits next to the general complex multiplier that follows each radix-2^3 group in a single-path streaming FFT. On every accepted sample it produces the angle that a sine/cosine generator needs to form that sample's twiddle factor. The angle is written as an unsigned phase word in which the full word range stands for one complete turn. Each instance has a fixed stage size `STAGE_N`. A deep pipeline uses one instance per position, with sizes such as 4096, 512 and 64. When several parallel channels sit at the same pipeline position, they all take their twiddle angle from one shared instance.

The instance counts accepted samples inside the frame. The three low bits of that count select a bit-reversed index that steps through 0, 4, 2, 6, 1, 5, 3, 7. The remaining bits form a ramp index that runs from 0 to `STAGE_N`/8-1 and advances once for every complete pass of the bit-reversed index. The phase is the product of the two indices, taken modulo `STAGE_N`, then shifted left so that `STAGE_N` fills the whole phase word. A start-of-frame flag that arrives with a valid sample sets the count back to zero. The valid flag passes through a fixed-depth pipeline, so it arrives at the output aligned with the data path.

Top module: `twiddle_angle_seq`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `valid_out`=0 and `phase_out`=0, and the sample count is cleared. The first valid sample after reset is therefore index 0 even without `sof_in`.
- R2: For in-frame sample index k, the ramp index is k>>3 and the bit-reversed index is k[0]*4 + k[1]*2 + k[2]. Samples k=8..15 therefore give the multiples 0,4,2,6,1,5,3,7.
- R3: `phase_out` = ((k>>3) * bitrev3(k[2:0]) mod `STAGE_N`) * 2^(`PHASE_W`-log2(`STAGE_N`)). With `STAGE_N`=64 and `PHASE_W`=12, sample 9 gives 4*64 = 256.
- R4: A sample with `valid_in`=1 and `sof_in`=1 takes index 0, which gives phase 0. The sample after it takes index 1, even in the middle of a frame.
- R5: After sample `STAGE_N`-1 (phase 49*2^shift for the largest indices 7*7 at `STAGE_N`=64), the next valid sample takes index 0 without any `sof_in`.
- R6: In a cycle with `valid_in`=0, the count does not move and `sof_in` has no effect.
- R7: `valid_out` equals `valid_in` delayed by 2+`EXTRA_LAT` clock cycles.
- R8: While `valid_out` is low, `phase_out` keeps the last valid phase, or 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | A sample is accepted this cycle |
| sof_in | input | 1 | The accepted sample is the first of a frame |
| phase_out | output | PHASE_W | Twiddle angle; 2^PHASE_W equals one full turn |
| valid_out | output | 1 | phase_out belongs to an accepted sample |

## Verification
The bench goes after the cases where the two indices have to line up exactly. Samples 8 to 15 expose the bit-reversed order: a design that stepped the index linearly would put out 0,1,2,3… times the scale. Advancing the ramp on every sample instead of every eighth would make the phase non-zero already within the first eight samples. A restart in the middle of a frame, a start flag that arrives without a valid sample, and gaps in the valid stream each catch a counter that resets or advances at the wrong time. The frame wrap after index 63, with its peak product of 49, catches a count that saturates or needs an extra start flag. The output is also checked during idle cycles, and a single valid sample is checked for the exact cycle in which it appears; together these expose a phase that drifts while no sample is valid and a latency that is off by one.

// File: rtl/twa_pkg.sv
package twa_pkg;

    // Control and bit-reversed index carried from the counter stage
    typedef struct packed {
        logic       vld;
        logic [2:0] rev;
    } twa_slot_t;

    // Reverse the order of three bits
    function automatic logic [2:0] twa_bitrev3(input logic [2:0] v);
        return {v[0], v[1], v[2]};
    endfunction

    // Total output latency for a given number of extra alignment stages
    function automatic int twa_total_lat(input int extra);
        return 2 + extra;
    endfunction

endpackage

// File: rtl/twa_index_ctr.sv
module twa_index_ctr
    import twa_pkg::*;
#(
    parameter int STAGE_N = 4096
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               vld_i,
    input  logic                               sof_i,
    output logic [$clog2(STAGE_N)-3-1:0]       ramp_o,
    output twa_slot_t                          slot_o
);
    localparam int IDX_W  = $clog2(STAGE_N);
    localparam int RAMP_W = IDX_W - 3;

    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] cur_idx;

    // Start of frame forces index zero for this very sample
    always_comb cur_idx = sof_i ? '0 : cnt_q;

    // Count wraps by width at STAGE_N
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (vld_i) begin
            cnt_q <= cur_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_o     <= '0;
            slot_o.vld <= 1'b0;
            slot_o.rev <= '0;
        end else begin
            slot_o.vld <= vld_i;
            if (vld_i) begin
                ramp_o     <= cur_idx[IDX_W-1:3];
                slot_o.rev <= twa_bitrev3(cur_idx[2:0]);
            end
        end
    end

    initial begin
        if (RAMP_W < 1) $display("twa_index_ctr: STAGE_N must be at least 16");
    end
endmodule

// File: rtl/twa_phase_mul.sv
module twa_phase_mul
    import twa_pkg::*;
#(
    parameter int STAGE_N = 4096,
    parameter int PHASE_W = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [$clog2(STAGE_N)-3-1:0]       ramp_i,
    input  twa_slot_t                          slot_i,
    output logic [PHASE_W-1:0]                 phase_o,
    output logic                               vld_o
);
    localparam int IDX_W  = $clog2(STAGE_N);
    localparam int RAMP_W = IDX_W - 3;
    localparam int SHIFT  = PHASE_W - IDX_W;

    logic [IDX_W-1:0]   prod;
    logic [PHASE_W-1:0] scaled;

    // Keeping IDX_W bits is the reduction modulo STAGE_N
    always_comb prod = {3'b000, ramp_i} * {{RAMP_W{1'b0}}, slot_i.rev};

    generate
        if (SHIFT > 0) begin : g_scale
            assign scaled = {prod, {SHIFT{1'b0}}};
        end else begin : g_noscale
            assign scaled = prod;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= slot_i.vld;
            if (slot_i.vld) begin
                phase_o <= scaled;
            end
        end
    end
endmodule

// File: rtl/twa_align_dly.sv
module twa_align_dly #(
    parameter int PHASE_W = 16,
    parameter int DEPTH   = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               vld_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               vld_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign phase_o = phase_i;
            assign vld_o   = vld_i;
        end else begin : g_chain
            logic [DEPTH:0]     v_c;
            logic [PHASE_W-1:0] p_c [DEPTH+1];

            assign v_c[0] = vld_i;
            assign p_c[0] = phase_i;

            for (genvar g = 0; g < DEPTH; g++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        v_c[g+1] <= 1'b0;
                        p_c[g+1] <= '0;
                    end else begin
                        v_c[g+1] <= v_c[g];
                        if (v_c[g]) p_c[g+1] <= p_c[g];
                    end
                end
            end

            assign phase_o = p_c[DEPTH];
            assign vld_o   = v_c[DEPTH];
        end
    endgenerate
endmodule

// File: rtl/twiddle_angle_seq.sv
module twiddle_angle_seq
    import twa_pkg::*;
#(
    parameter int STAGE_N   = 4096,
    parameter int PHASE_W   = 16,
    parameter int EXTRA_LAT = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic               sof_in,
    output logic [PHASE_W-1:0] phase_out,
    output logic               valid_out
);
    localparam int IDX_W     = $clog2(STAGE_N);
    localparam int RAMP_W    = IDX_W - 3;
    localparam int TOTAL_LAT = twa_total_lat(EXTRA_LAT);

    logic [RAMP_W-1:0]  ramp_s1;
    twa_slot_t          slot_s1;
    logic [PHASE_W-1:0] phase_s2;
    logic               vld_s2;

    twa_index_ctr #(.STAGE_N(STAGE_N)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (valid_in),
        .sof_i  (sof_in),
        .ramp_o (ramp_s1),
        .slot_o (slot_s1)
    );

    twa_phase_mul #(.STAGE_N(STAGE_N), .PHASE_W(PHASE_W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .ramp_i  (ramp_s1),
        .slot_i  (slot_s1),
        .phase_o (phase_s2),
        .vld_o   (vld_s2)
    );

    twa_align_dly #(.PHASE_W(PHASE_W), .DEPTH(EXTRA_LAT)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_s2),
        .vld_i   (vld_s2),
        .phase_o (phase_out),
        .vld_o   (valid_out)
    );
endmodule

// File: rtl/twa_seq_chk.sv
module twa_seq_chk #(
    parameter int LAT     = 2,
    parameter int PHASE_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               valid_in,
    input logic               sof_in,
    input logic [PHASE_W-1:0] phase_out,
    input logic               valid_out
);
    logic [LAT-1:0] v_sr;
    logic [LAT-1:0] s_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_sr <= '0;
            s_sr <= '0;
        end else begin
            v_sr <= {v_sr[LAT-2:0], valid_in};
            s_sr <= {s_sr[LAT-2:0], valid_in & sof_in};
        end
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!valid_out && phase_out == '0));

    // R7
    p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
        valid_out == v_sr[LAT-1]);

    // R4
    p_sof_zero_r4: assert property (@(posedge clk) disable iff (rst)
        s_sr[LAT-1] |-> (valid_out && phase_out == '0));

    // R8
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> $stable(phase_out));
endmodule

bind twiddle_angle_seq twa_seq_chk #(.LAT(TOTAL_LAT), .PHASE_W(PHASE_W)) u_twa_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .sof_in    (sof_in),
    .phase_out (phase_out),
    .valid_out (valid_out)
);

// File: tb/twiddle_angle_seq_test.sv
module twiddle_angle_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int TN  = 64;
    localparam int PW  = 12;
    localparam int SH  = 6;
    localparam int NT  = 23;

    // entry: {sof, valid, expected phase in units of 2^SH}
    localparam logic [7:0] TBL [NT] = '{
        {1'b1, 1'b1, 6'd0},  // k0 R4
        {1'b0, 1'b1, 6'd0},  // k1
        {1'b0, 1'b0, 6'd0},  // gap R6
        {1'b1, 1'b0, 6'd0},  // sof without valid, ignored R6
        {1'b0, 1'b1, 6'd0},  // k2
        {1'b0, 1'b1, 6'd0},
        {1'b0, 1'b1, 6'd0},
        {1'b0, 1'b1, 6'd0},
        {1'b0, 1'b1, 6'd0},
        {1'b0, 1'b1, 6'd0},  // k7
        {1'b0, 1'b1, 6'd0},  // k8  R2
        {1'b0, 1'b1, 6'd4},
        {1'b0, 1'b1, 6'd2},
        {1'b0, 1'b1, 6'd6},
        {1'b0, 1'b1, 6'd1},
        {1'b0, 1'b1, 6'd5},
        {1'b0, 1'b1, 6'd3},
        {1'b0, 1'b1, 6'd7},  // k15
        {1'b0, 1'b0, 6'd0},  // gap
        {1'b0, 1'b1, 6'd0},  // k16
        {1'b0, 1'b1, 6'd8},  // k17 R3
        {1'b1, 1'b1, 6'd0},  // mid-frame restart R4
        {1'b0, 1'b1, 6'd0}   // k1
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic          sof_in = 1'b0;
    logic [PW-1:0] phase_out;
    logic          valid_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic          hv [2];
    int            hp [2];
    string         hr [2];
    int            last_p;
    int            mk;

    always #(CLK_PERIOD/2) clk = ~clk;

    twiddle_angle_seq #(.STAGE_N(TN), .PHASE_W(PW), .EXTRA_LAT(0)) uut (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .sof_in    (sof_in),
        .phase_out (phase_out),
        .valid_out (valid_out)
    );

    function automatic int brev(input int k);
        return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
    endfunction

    function automatic int model_phase(input int k);
        return (((k >> 3) * brev(k & 7)) % TN) << SH;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: check the output due now, then drive the next input
    task automatic step(input bit s, input bit v, input int exp_p, input string req);
        @(negedge clk);
        check(valid_out == hv[1], "R7", {"valid_out ", hr[1]}, int'(valid_out), int'(hv[1]));
        if (hv[1]) begin
            check(int'(phase_out) == hp[1], hr[1], "phase", int'(phase_out), hp[1]);
            last_p = hp[1];
        end else begin
            check(int'(phase_out) == last_p, "R8", "idle phase", int'(phase_out), last_p);
        end
        hv[1] = hv[0]; hp[1] = hp[0]; hr[1] = hr[0];
        hv[0] = v;     hp[0] = exp_p; hr[0] = req;
        sof_in   = s;
        valid_in = v;
    endtask

    task automatic model_step(input bit s, input bit v, input string req);
        int idx;
        int e;
        e = 0;
        if (v) begin
            idx = s ? 0 : mk;
            e = model_phase(idx);
            mk = (idx + 1) % TN;
        end
        step(s, v, e, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b0; sof_in = 1'b0;
        repeat (2) @(negedge clk);
        check(valid_out == 1'b0, "R1", "valid_out in reset", int'(valid_out), 0);
        check(phase_out == '0, "R1", "phase in reset", int'(phase_out), 0);
        rst = 1'b0;
        hv[0] = 1'b0; hv[1] = 1'b0; hp[0] = 0; hp[1] = 0;
        hr[0] = "R1"; hr[1] = "R1";
        last_p = 0; mk = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Vector table
        for (int i = 0; i < NT; i++) begin
            step(TBL[i][7], TBL[i][6], int'(TBL[i][5:0]) << SH,
                 TBL[i][7] ? "R4" : (TBL[i][6] ? "R3" : "R6"));
        end
        // Bring the model in line with the design: index 2 is next
        mk = 2;

        // Two complete frames with periodic gaps; crosses the wrap R5
        model_step(1'b1, 1'b1, "R4");
        for (int c = 1; c < 2 * TN + 20; c++) begin
            if (c % 13 == 0) model_step(1'b1, 1'b0, "R6");
            else             model_step(1'b0, 1'b1, (mk == 0) ? "R5" : "R2");
        end

        // Single isolated sample: latency and idle hold
        repeat (3) model_step(1'b0, 1'b0, "R8");
        model_step(1'b0, 1'b1, "R7");
        repeat (4) model_step(1'b0, 1'b0, "R7");

        // Reset mid-frame, then count restarts at index 0 with no sof
        do_reset();
        for (int c = 0; c < 12; c++) model_step(1'b0, 1'b1, "R1");
        repeat (3) model_step(1'b0, 1'b0, "R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule